// File: doc/BRIEF.md
# Entropy CRC Accumulator with Read Interlock

The block turns raw random bits into a 64-bit conditioned word. Three single-bit noise inputs are sampled every clock. Each input can be switched on or off. The bits that are switched on are combined by exclusive-OR into one bit, and that bit is clocked into a 64-bit CRC register. The register is the random output word, and a consumer reads it through a valid/ready handshake.

A control word holds the source enables, an interlock mode bit and a wait count. With the interlock on, the read port holds off a new read until the wait count of cycles has gone by since the previous completed read. Extra entropy is folded into the register during that gap. With the interlock off, every read completes at once with the current register value.

Top module: `entropy_crc_acc`

## Requirements
- R1: An asynchronous active-low reset clears the CRC state to zero and clears the control word (all sources off, interlock off, wait 0). After reset, rd_data reads 0 and rd_ready is 1.
- R2: When cfg_we is high at a clock edge, cfg_wdata is loaded into the control word and takes effect from the next cycle. The layout is: bit i (i = 0..2) enables noise_in[i], bit 3 turns the interlock on, and bits [15:4] hold the wait count W.
- R3: A disabled source contributes 0. With all sources disabled, the CRC input bit is 0, so a zero CRC state stays zero whatever the noise inputs do.
- R4: The CRC input bit is the XOR of noise_in[i] AND enable[i] over all three sources.
- R5: At each clock edge, with input bit d and state q, let fb = q[63] XOR d. The new state is (q << 1) XOR (fb ? P : 0). P has ones at bit positions 61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37, 35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1 and 0.
- R6: rd_data always shows the current CRC state. A read completes at a clock edge where rd_valid and rd_ready are both high.
- R7: With the interlock off, rd_ready is always 1.
- R8: With the interlock on and W > 0, rd_ready is 0 for exactly W cycles after a completed read. While rd_valid is held high, successive reads complete W+1 edges apart.
- R9: The interlock counter saturates at W. A read that arrives after a long idle time is accepted at once, and with W = 0 a read completes on every cycle.
- R10: Only a completed read restarts the interlock counter. Once rd_ready is 1 with the interlock on, it stays 1 until a read completes or the control word is rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| noise_in | input | 3 | Raw noise bits, one per source |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value: enables, interlock mode, wait count |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read may complete this cycle |
| rd_data | output | 64 | Current CRC state |

## Verification
The bench aims at the read spacing under the interlock. It holds a request high and measures the gap between ready cycles. An off-by-one in the counter would show up as reads W or W+2 edges apart instead of W+1. It also leaves the port idle past the wait time and expects immediate acceptance, and it runs with a zero wait count. A counter that does not saturate, or that restarts on requests that never complete, would stall there. A zero register is fed with all sources disabled while the noise toggles, which catches any leakage through a disabled gate. Random control writes and noise are checked cycle by cycle against an independently tabled polynomial, which exposes a wrong tap, a wrong feedback bit, or an enable that acts one cycle early or late.

// File: rtl/ecrc_pkg.sv
package ecrc_pkg;

  localparam int CRC_W = 64;

  // Build the low 64 coefficients of the generator (x^64 is implicit).
  function automatic logic [CRC_W-1:0] build_taps();
    logic [CRC_W-1:0] p;
    p = '0;
    p[0]  = 1'b1; p[1]  = 1'b1; p[5]  = 1'b1; p[7]  = 1'b1;
    p[11] = 1'b1; p[12] = 1'b1; p[13] = 1'b1; p[15] = 1'b1;
    p[17] = 1'b1; p[21] = 1'b1; p[22] = 1'b1; p[25] = 1'b1;
    p[28] = 1'b1; p[32] = 1'b1; p[35] = 1'b1; p[37] = 1'b1;
    p[38] = 1'b1; p[39] = 1'b1; p[41] = 1'b1; p[42] = 1'b1;
    p[43] = 1'b1; p[46] = 1'b1; p[47] = 1'b1; p[48] = 1'b1;
    p[50] = 1'b1; p[51] = 1'b1; p[52] = 1'b1; p[56] = 1'b1;
    p[57] = 1'b1; p[61] = 1'b1;
    return p;
  endfunction

  localparam logic [CRC_W-1:0] CRC_TAPS = build_taps();

  // One serial CRC step: feedback is the top bit XOR the incoming bit.
  function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] q,
                                                   input logic d);
    logic fb;
    fb = q[CRC_W-1] ^ d;
    return {q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  // The read gate is open when the interlock is off or the count has reached the wait.
  function automatic logic gate_open(input logic mode, input int unsigned cnt,
                                     input int unsigned wait_cyc);
    return !mode || (cnt >= wait_cyc);
  endfunction

endpackage

// File: rtl/ecrc_ctl.sv
module ecrc_ctl #(
  parameter int NUM_SRC = 3,
  parameter int WAIT_W  = 12,
  localparam int CTL_W  = NUM_SRC + 1 + WAIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CTL_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] src_en,
  output logic               lock_on,
  output logic [WAIT_W-1:0]  wait_cyc
);

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= wdata;
    end
  end

  assign src_en   = ctl_q[NUM_SRC-1:0];
  assign lock_on  = ctl_q[NUM_SRC];
  assign wait_cyc = ctl_q[CTL_W-1:NUM_SRC+1];

endmodule

// File: rtl/ecrc_mix.sv
module ecrc_mix #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] noise,
  input  logic [NUM_SRC-1:0] en,
  output logic               bit_out
);

  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign gated[i] = noise[i] & en[i];
  end

  assign bit_out = ^gated;

endmodule

// File: rtl/ecrc_crc.sv
module ecrc_crc
  import ecrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [CRC_W-1:0] state
);

  logic [CRC_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= crc_advance(state_q, din);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ecrc_gate.sv
module ecrc_gate
  import ecrc_pkg::*;
#(
  parameter int WAIT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_on,
  input  logic [WAIT_W-1:0] wait_cyc,
  input  logic              req,
  output logic              ready,
  output logic              fire
);

  logic [WAIT_W-1:0] cnt_q;

  assign ready = gate_open(lock_on, int'(cnt_q), int'(wait_cyc));
  assign fire  = req & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= '0;
    end else if (cnt_q < wait_cyc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/entropy_crc_acc.sv
module entropy_crc_acc
  import ecrc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int WAIT_W  = 12,
  localparam int CTL_W  = NUM_SRC + 1 + WAIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] noise_in,
  input  logic               cfg_we,
  input  logic [CTL_W-1:0]   cfg_wdata,
  input  logic               rd_valid,
  output logic               rd_ready,
  output logic [CRC_W-1:0]   rd_data
);

  // Named internal events for the checker.
  logic [NUM_SRC-1:0] ctl_en;
  logic               ctl_lock;
  logic [WAIT_W-1:0]  ctl_wait;
  logic               mix_bit;
  logic               rd_fire;
  logic [CRC_W-1:0]   crc_q;

  ecrc_ctl #(.NUM_SRC(NUM_SRC), .WAIT_W(WAIT_W)) i_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .src_en   (ctl_en),
    .lock_on  (ctl_lock),
    .wait_cyc (ctl_wait)
  );

  ecrc_mix #(.NUM_SRC(NUM_SRC)) i_mix (
    .noise   (noise_in),
    .en      (ctl_en),
    .bit_out (mix_bit)
  );

  ecrc_crc i_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mix_bit),
    .state (crc_q)
  );

  ecrc_gate #(.WAIT_W(WAIT_W)) i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_on  (ctl_lock),
    .wait_cyc (ctl_wait),
    .req      (rd_valid),
    .ready    (rd_ready),
    .fire     (rd_fire)
  );

  assign rd_data = crc_q;

endmodule

// File: rtl/ecrc_chk.sv
module ecrc_chk #(
  parameter int NUM_SRC = 3,
  parameter int WAIT_W  = 12,
  localparam int CTL_W  = NUM_SRC + 1 + WAIT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [CTL_W-1:0]   cfg_wdata,
  input logic [NUM_SRC-1:0] ctl_en,
  input logic               ctl_lock,
  input logic [WAIT_W-1:0]  ctl_wait,
  input logic               mix_bit,
  input logic               rd_fire,
  input logic               rd_ready,
  input logic [63:0]        crc_q
);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ({ctl_wait, ctl_lock, ctl_en} == $past(cfg_wdata)));

  // R3
  src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en == '0) |-> !mix_bit);

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q == 64'd0 && ctl_en == '0) |=> (crc_q == 64'd0));

  // R7
  free_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_lock |-> rd_ready);

  // R8
  hold_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ctl_lock && ctl_wait != '0 && !cfg_we) |=> !rd_ready);

  // R10
  stay_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_fire && !cfg_we) |=> rd_ready);

endmodule

bind entropy_crc_acc ecrc_chk #(.NUM_SRC(NUM_SRC), .WAIT_W(WAIT_W)) i_ecrc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .ctl_en    (ctl_en),
  .ctl_lock  (ctl_lock),
  .ctl_wait  (ctl_wait),
  .mix_bit   (mix_bit),
  .rd_fire   (rd_fire),
  .rd_ready  (rd_ready),
  .crc_q     (crc_q)
);

// File: tb/test_entropy_crc_acc.sv
`timescale 1ns/1ps
module test_entropy_crc_acc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  noise_in = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  entropy_crc_acc i_entropy_crc_acc (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  // Reference model state
  logic [63:0] m_crc;
  logic [2:0]  m_en;
  logic        m_lock;
  int          m_wait;
  int          m_cnt;

  // Polynomial exponents below x^64, as a table walked at run time (R5).
  function automatic logic [63:0] ref_step(input logic [63:0] q, input logic d);
    int expo [30] = '{61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37,
                      35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1, 0};
    logic top;
    logic [63:0] r;
    top = q[63] ^ d;
    r = q << 1;
    if (top) begin
      for (int k = 0; k < 30; k++) r[expo[k]] = ~r[expo[k]];
    end
    return r;
  endfunction

  function automatic logic ref_ready();
    return (m_lock == 1'b0) || (m_cnt >= m_wait);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic tick();
    logic d;
    logic hs;
    @(posedge clk);
    hs = rd_valid && ref_ready();
    d = (noise_in[0] & m_en[0]) ^ (noise_in[1] & m_en[1]) ^ (noise_in[2] & m_en[2]);
    m_crc = ref_step(m_crc, d);
    if (hs) m_cnt = 0;
    else if (m_cnt < m_wait) m_cnt = m_cnt + 1;
    if (cfg_we) begin
      m_en   = cfg_wdata[2:0];
      m_lock = cfg_wdata[3];
      m_wait = int'(cfg_wdata[15:4]);
    end
    @(negedge clk);
    check(rd_data == m_crc, "R5 R4 R6 crc state", rd_data, m_crc);
    check(rd_ready == ref_ready(), "R7 R8 ready", 64'(rd_ready), 64'(ref_ready()));
  endtask

  task automatic write_ctl(input logic [11:0] w, input logic lock, input logic [2:0] en);
    cfg_we = 1'b1;
    cfg_wdata = {w, lock, en};
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    int ready_at [$];
    seed_sink = $urandom(32'h5EED_0042);
    m_crc = '0; m_en = '0; m_lock = 1'b0; m_wait = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(rd_data == 64'd0, "R1 reset crc", rd_data, 64'd0);
    check(rd_ready == 1'b1, "R1 reset ready", 64'(rd_ready), 64'd1);

    // R3: sources all off, noise toggling, state must stay zero.
    for (int i = 0; i < 40; i++) begin
      noise_in = 3'($urandom());
      tick();
    end
    check(rd_data == 64'd0, "R3 disabled sources", rd_data, 64'd0);

    // R4: single source, then pairs, driving a constant one.
    noise_in = 3'b111;
    write_ctl(12'd0, 1'b0, 3'b010);
    repeat (10) tick();
    write_ctl(12'd0, 1'b0, 3'b011);
    repeat (10) tick();
    write_ctl(12'd0, 1'b0, 3'b111);
    repeat (10) tick();

    // R7: interlock off, valid held, reads every cycle.
    rd_valid = 1'b1;
    repeat (8) begin
      tick();
      check(rd_ready == 1'b1, "R7 free running read", 64'(rd_ready), 64'd1);
    end

    // R8: W = 5, valid held, ready pattern period W+1.
    write_ctl(12'd5, 1'b1, 3'b101);
    for (int i = 0; i < 40; i++) begin
      noise_in = 3'($urandom());
      tick();
      if (rd_ready) ready_at.push_back(i);
    end
    check(ready_at.size() >= 5, "R8 reads happen", 64'(ready_at.size()), 64'd5);
    for (int k = 1; k < ready_at.size(); k++)
      check(ready_at[k] - ready_at[k-1] == 6, "R8 read spacing",
            64'(ready_at[k] - ready_at[k-1]), 64'd6);

    // R9: W = 0 with interlock on, ready every cycle.
    write_ctl(12'd0, 1'b1, 3'b111);
    repeat (6) begin
      tick();
      check(rd_ready == 1'b1, "R9 zero wait", 64'(rd_ready), 64'd1);
    end

    // R10 / R9: idle past the wait, ready stays high, first read is immediate.
    rd_valid = 1'b0;
    write_ctl(12'd4, 1'b1, 3'b111);
    repeat (20) tick();
    check(rd_ready == 1'b1, "R10 ready held while idle", 64'(rd_ready), 64'd1);
    rd_valid = 1'b1;
    tick();
    check(rd_ready == 1'b0, "R9 read accepted after idle", 64'(rd_ready), 64'd0);
    rd_valid = 1'b0;

    // Random mix of control writes, noise and requests (R2 and all).
    for (int i = 0; i < 4000; i++) begin
      noise_in = 3'($urandom());
      rd_valid = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 40) == 0) begin
        cfg_we = 1'b1;
        cfg_wdata = {12'($urandom_range(0, 7)), 1'($urandom()), 3'($urandom())};
      end else begin
        cfg_we = 1'b0;
      end
      tick();
    end
    cfg_we = 1'b0;
    rd_valid = 1'b0;

    // R1: reset again clears everything mid-run.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rd_data == 64'd0, "R1 reset mid run", rd_data, 64'd0);
    check(rd_ready == 1'b1, "R1 reset ready mid run", 64'(rd_ready), 64'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule